// File: doc/BRIEF.md
# Two-Array I2C Byte Memory Target

This block is an I2C target, sampled by a fast system clock, that serves two byte arrays of 2^ADDR_W entries each. A nonvolatile-style array answers to any control byte whose upper four bits are 1010. A scratch SRAM array answers to the upper seven bits 1101111. Both arrays sit behind one word pointer. Every load and every access moves that pointer, so a current-address read continues from wherever the last transaction on either array left off.

The host sets the pointer with a write-mode control byte followed by a word address. It can then store data bytes, or it can abandon the write with a repeated Start and issue a read-mode control byte (a random read). While the host acknowledges each byte, read data keeps streaming from successive addresses. A plain control input, `prot_sel`, fences off part of the nonvolatile array against writes. SDA is open drain: the block only pulls it low (`sda_oe`), and it never drives SCL.

Top module: `i2cmem_target`

## Requirements
- R1: A control byte whose bits 7..4 are 1010 selects the array (bits 3..1 are ignored), and one whose bits 7..1 are 1101111 selects the SRAM. Bit 0 is R/W, with 1 meaning read. For a matching control byte the target pulls SDA low during the ninth clock.
- R2: For a control byte that matches neither code, SDA stays released in the ninth clock. The target then acknowledges and stores nothing until the next Start.
- R3: In a write, the control byte, the word address and each data byte are acknowledged. The word address bit 7 is ignored. The data byte is stored at the pointer, and afterwards the pointer holds that address plus one.
- R4: Read data is shifted out most significant bit first. Each bit is placed while SCL is low, beginning after the acknowledge of the read-mode control byte.
- R5: A current-address read returns the byte at the pointer and then advances the pointer. The pointer wraps from the highest address to 0.
- R6: A word address followed by a repeated Start loads the pointer without storing anything. The read that follows returns the byte at that address.
- R7: When the host acknowledges a read byte, the byte at the next address follows. When it does not, the target releases SDA and drives nothing until the next Start.
- R8: Both arrays share one pointer but hold separate contents.
- R9: `prot_sel` protects part of the array and never the SRAM. The encodings are 0 = nothing, 1 = top quarter (addresses from 3/4 of depth upward), 2 = top half, 3 = all. A write to a protected address is acknowledged and discarded, and the pointer still advances.
- R10: A Start or a Stop at any bit position abandons the byte in progress and releases SDA. A Start restarts control-byte reception, and a partial data byte cut off by Stop is not stored.
- R11: After reset SDA is released, the pointer is 0 and both arrays read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | High pulls SDA to the level on sda_o |
| sda_o | output | 1 | SDA drive level, always 0 (open drain) |
| prot_sel | input | 2 | Array write-protection range selector |

## Verification
Within one system clock, the end of a write data byte stores the byte at the pointer and also steps the pointer. The same happens on a read, where loading the transmit byte and advancing the pointer share a cycle. The bench provokes this at the wrap boundary by writing the last address and then issuing a current-address read, which must return address 0. It also provokes it on a protected address, where the store must be suppressed while the step still occurs: a following current-address read must return the byte one above the discarded write.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
  localparam int BYTE_W = 8;
  localparam int NBANK  = 2;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [3:0] ARR_CODE  = 4'b1010;
  localparam logic [6:0] SRAM_CODE = 7'b1101111;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ACK_CTRL,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2cmem_line_sync.sv
module i2cmem_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  // two-flop synchronisers, idle-high reset so no false edge appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cmem_bank.sv
module i2cmem_bank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       sda_o,
  input  logic [1:0] prot_sel
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cmem_line_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  tgt_state_e          state;
  logic [CNT_W-1:0]    cnt;
  logic [BYTE_W-1:0]   sh;
  logic [BYTE_W-1:0]   tx;
  logic [ADDR_W-1:0]   ptr;
  logic                bank;
  logic                rw;
  logic                mack;

  logic [BYTE_W-1:0]   bank_rd [NBANK];
  logic [NBANK-1:0]    bank_we;
  logic [BYTE_W-1:0]   cur_rd;
  logic                byte_done, ptr_load, wr_fire, prot_hit;
  logic                code_arr, code_sram;

  assign sda_o     = 1'b0;
  assign byte_done = scl_fall && (cnt == CNT_FULL);
  assign code_arr  = (sh[7:4] == ARR_CODE);
  assign code_sram = (sh[7:1] == SRAM_CODE);
  assign ptr_load  = (state == ST_ADDR) && byte_done;
  assign wr_fire   = (state == ST_WDATA) && byte_done;
  assign cur_rd    = bank_rd[bank];

  // protected range of the array, chosen by the two top pointer bits
  always_comb begin
    unique case (prot_sel)
      2'd0:    prot_hit = 1'b0;
      2'd1:    prot_hit = &ptr[ADDR_W-1 -: 2];
      2'd2:    prot_hit = ptr[ADDR_W-1];
      default: prot_hit = 1'b1;
    endcase
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_we[g] = wr_fire && (bank == 1'(g)) && !((g == 0) && prot_hit);
    i2cmem_bank #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (bank_we[g]),
      .addr (ptr),
      .wdata(sh),
      .rdata(bank_rd[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      bank   <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_CTRL;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise && (cnt < CNT_FULL)) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            if (state == ST_CTRL) begin
              if (code_arr || code_sram) begin
                bank   <= code_sram;
                rw     <= sh[0];
                sda_oe <= 1'b1;
                state  <= ST_ACK_CTRL;
              end else begin
                state  <= ST_IDLE;
              end
            end else if (state == ST_ADDR) begin
              ptr    <= sh[ADDR_W-1:0];
              sda_oe <= 1'b1;
              state  <= ST_ACK_ADDR;
            end else begin
              ptr    <= ptr + 1'b1;
              sda_oe <= 1'b1;
              state  <= ST_ACK_WDATA;
            end
          end
        end
        ST_ACK_CTRL: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx     <= cur_rd;
              ptr    <= ptr + 1'b1;
              sda_oe <= ~cur_rd[BYTE_W-1];
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_ADDR;
            end
          end
        end
        ST_ACK_ADDR, ST_ACK_WDATA: begin
          if (scl_fall) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt == CNT_LAST) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_W-2];
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx     <= cur_rd;
              ptr    <= ptr + 1'b1;
              sda_oe <= ~cur_rd[BYTE_W-1];
              cnt    <= '0;
              state  <= ST_RDATA;
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cmem_target_chk.sv
module i2cmem_target_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic [ADDR_W-1:0] ptr,
  input logic              ptr_load,
  input logic              arr_we,
  input logic [1:0]        prot_sel
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] ptr_inc;
  logic              fenced;
  assign ptr_inc = ptr + 1'b1;
  assign fenced  = (prot_sel == 2'd3) ||
                   ((prot_sel == 2'd2) && (int'(ptr) >= DEPTH / 2)) ||
                   ((prot_sel == 2'd1) && (int'(ptr) >= (DEPTH / 4) * 3));

  // R10: Start releases SDA
  p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R10: Stop releases SDA
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R4: the target only moves SDA while SCL is low
  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

  // R5: the pointer only steps by one (with wrap) or takes a word address
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> ((ptr == $past(ptr_inc)) || $past(ptr_load)));

  // R9: no array store lands inside the fenced range
  p_fence_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !fenced);
endmodule

bind i2cmem_target i2cmem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .ptr      (ptr),
  .ptr_load (ptr_load),
  .arr_we   (bank_we[0]),
  .prot_sel (prot_sel)
);

// File: tb/sim_i2cmem_target.sv
module sim_i2cmem_target;
  localparam int Q  = 8;
  localparam int WD = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] prot_sel = 2'd0;
  logic       sda_oe, sda_o, sda_bus;
  int         vectors = 0;
  int         miscmp = 0;

  always #10 clk = ~clk;

  assign sda_bus = sda_oe ? sda_o : sda_m;

  i2cmem_target u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .sda_oe  (sda_oe),
    .sda_o   (sda_o),
    .prot_sel(prot_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
  endtask

  task automatic m_bit(input logic b);
    sda_m = b; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
  endtask

  task automatic m_sample(output logic b);
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; b = sda_bus; wq; scl_m = 1'b0; wq;
  endtask

  task automatic m_send(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit(d[i]);
    m_sample(b);
    ack = ~b;
  endtask

  task automatic m_recv(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_sample(d[i]);
    m_bit(~give_ack);
  endtask

  task automatic wr(input logic [7:0] ctl, input logic [7:0] addr,
                    input logic [7:0] data, input string req);
    logic a1, a2, a3;
    m_start; m_send(ctl, a1); m_send(addr, a2); m_send(data, a3); m_stop;
    chk(req, {5'b0, a1, a2, a3}, 8'h07);
  endtask

  task automatic rd_rand(input logic [7:0] ctl, input logic [7:0] addr,
                         output logic [7:0] d);
    logic a;
    m_start; m_send(ctl & 8'hFE, a); m_send(addr, a);
    m_start; m_send(ctl | 8'h01, a); m_recv(1'b0, d); m_stop;
  endtask

  task automatic rd_cur(input logic [7:0] ctl, output logic [7:0] d);
    logic a;
    m_start; m_send(ctl | 8'h01, a); m_recv(1'b0, d); m_stop;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R11 sda released", {7'b0, sda_oe}, 8'h00);
    rd_cur(8'hA0, d); chk("R11 array zero", d, 8'h00);
    rd_cur(8'hDE, d); chk("R11 sram zero", d, 8'h00);
  endtask

  task automatic t_byte_write;
    logic [7:0] d;
    wr(8'hA0, 8'h06, 8'h5E, "R3 acks");
    wr(8'hAE, 8'h85, 8'hA5, "R1 dont-care code bits acked");
    rd_cur(8'hA0, d); chk("R3 pointer addr+1", d, 8'h5E);
    rd_rand(8'hA0, 8'h05, d); chk("R6 random read, R3 msb ignored", d, 8'hA5);
  endtask

  task automatic t_shared_ptr;
    logic [7:0] d;
    wr(8'hA0, 8'h0B, 8'h77, "R3 array write");
    wr(8'hDE, 8'h0A, 8'h3C, "R1 sram write acks");
    rd_rand(8'hDE, 8'h0A, d); chk("R1 sram read", d, 8'h3C);
    rd_cur(8'hA0, d); chk("R8 shared pointer", d, 8'h77);
    rd_rand(8'hA0, 8'h0A, d); chk("R8 separate contents", d, 8'h00);
  endtask

  task automatic t_seq_read;
    logic [7:0] d;
    logic a, b;
    wr(8'hA0, 8'h20, 8'h96, "R3 seq setup");
    wr(8'hA0, 8'h21, 8'h3B, "R3 seq setup");
    wr(8'hA0, 8'h22, 8'hF0, "R3 seq setup");
    m_start; m_send(8'hA0, a); m_send(8'h20, a);
    m_start; m_send(8'hA1, a);
    chk("R1 read ctrl ack", {7'b0, a}, 8'h01);
    m_recv(1'b1, d); chk("R4 msb first", d, 8'h96);
    m_recv(1'b1, d); chk("R7 next byte", d, 8'h3B);
    m_recv(1'b0, d); chk("R7 third byte", d, 8'hF0);
    m_sample(b); chk("R7 released after nack", {7'b0, b}, 8'h01);
    m_sample(b); chk("R7 still released", {7'b0, b}, 8'h01);
    m_stop;
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    wr(8'hA0, 8'h00, 8'hE1, "R3 wrap setup");
    wr(8'hA0, 8'h7F, 8'h5A, "R3 last address");
    rd_cur(8'hA0, d); chk("R5 write wraps pointer", d, 8'hE1);
    rd_rand(8'hA0, 8'h7F, d); chk("R5 last address data", d, 8'h5A);
    rd_cur(8'hA0, d); chk("R5 read wraps pointer", d, 8'hE1);
  endtask

  task automatic t_bad_code;
    logic [7:0] d;
    logic a, b;
    m_start;
    m_send(8'h90, a); chk("R2 foreign code nack", {7'b0, a}, 8'h00);
    m_send(8'h05, a); chk("R2 address ignored", {7'b0, a}, 8'h00);
    m_send(8'hFF, a); chk("R2 data ignored", {7'b0, a}, 8'h00);
    m_sample(b); chk("R2 line released", {7'b0, b}, 8'h01);
    m_stop;
    rd_rand(8'hA0, 8'h05, d); chk("R2 array untouched", d, 8'hA5);
  endtask

  task automatic t_protect;
    logic [7:0] d;
    wr(8'hA0, 8'h47, 8'hC3, "R9 setup");
    prot_sel = 2'd2;
    wr(8'hA0, 8'h46, 8'h11, "R9 protected write acked");
    rd_cur(8'hA0, d); chk("R9 pointer advanced", d, 8'hC3);
    rd_rand(8'hA0, 8'h46, d); chk("R9 half discarded", d, 8'h00);
    wr(8'hA0, 8'h28, 8'h22, "R9 lower half");
    rd_rand(8'hA0, 8'h28, d); chk("R9 lower half stored", d, 8'h22);
    prot_sel = 2'd3;
    wr(8'hDE, 8'h46, 8'h44, "R9 sram write");
    rd_rand(8'hDE, 8'h46, d); chk("R9 sram never fenced", d, 8'h44);
    wr(8'hA0, 8'h05, 8'h99, "R9 all fenced");
    rd_rand(8'hA0, 8'h05, d); chk("R9 all discarded", d, 8'hA5);
    prot_sel = 2'd1;
    wr(8'hA0, 8'h5A, 8'h66, "R9 below quarter");
    rd_rand(8'hA0, 8'h5A, d); chk("R9 below quarter stored", d, 8'h66);
    wr(8'hA0, 8'h64, 8'h77, "R9 top quarter");
    rd_rand(8'hA0, 8'h64, d); chk("R9 top quarter discarded", d, 8'h00);
    prot_sel = 2'd0;
  endtask

  task automatic t_abort;
    logic [7:0] d;
    logic a;
    m_start;
    for (int i = 7; i >= 4; i--) m_bit(1'b1 ^ (i[0]));
    m_start; m_send(8'hA1, a);
    chk("R10 start restarts control byte", {7'b0, a}, 8'h01);
    m_recv(1'b0, d); m_stop;
    m_start; m_send(8'hA0, a); m_send(8'h30, a);
    for (int i = 0; i < 4; i++) m_bit(1'b1);
    m_stop;
    chk("R10 released after stop", {7'b0, sda_oe}, 8'h00);
    rd_rand(8'hA0, 8'h30, d); chk("R10 partial byte not stored", d, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_byte_write;
    t_shared_ptr;
    t_seq_read;
    t_wrap;
    t_bad_code;
    t_protect;
    t_abort;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    vectors++;
    miscmp++;
    $display("FAIL R10 watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule